// File: doc/BRIEF.md
# Packet Store-Before-Load Sequencer

This block serialises the memory operations of one issue packet that carries up to two slots. When slot 1 holds a store and slot 0 holds a load, the two operations are not run side by side: the sequencer first checks the load address for a fault, then commits the store, and then performs the load. A load whose bytes overlap the store therefore returns the freshly written bytes. Any other packet shape is handled in plain slot order, slot 0 first, with no fault check.

A packet is handed over with a valid/ready handshake and carries, per slot, a valid bit, a store flag, a predicate, a sign flag, a size code, an address and store data. The block drives a single-port memory with one outstanding request at a time. Memory is little-endian and one data word wide. At the end of the packet it pulses a done output. Alongside that pulse it presents the extended load results, a per-slot cancel mask and an error flag. These outputs hold until the next packet is taken.

Top module: `pkt_sbl_seq`

## Requirements
- R1: When slot 1 is a valid store and slot 0 is a valid load, with both predicates true, the memory sees exactly three requests in this order: a probe at the load address (mem_kind 1), the slot 1 write (mem_kind 3), then the slot 0 read (mem_kind 2).
- R2: A load whose byte range overlaps a store issued earlier in the same packet returns the bytes written by that store.
- R3: If the memory returns mem_fault with the completion of a probe, no write and no read follow. done_o then pulses with err_o high and cancel_o equal to the valid bits of both slots. Memory contents are left unchanged.
- R4: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. A load of 1, 2 or 4 bytes is sign-extended to 64 bits when its sign flag is set and zero-extended otherwise.
- R5: Memory is little-endian and accesses are naturally aligned. mem_addr is the access address with its three low bits cleared. mem_be has one bit per byte, starting at bit addr[2:0] and covering as many bits as the access size. For a write, byte k of the store data appears on lane addr[2:0]+k of mem_wdata.
- R6: In the ordered case of R1, a load whose predicate is false gets no probe and no read, but the slot 1 store is still written.
- R7: cancel_o bit s (bit 0 for slot 0, bit 1 for slot 1) is set for each valid slot whose predicate is false. A cancelled slot makes no memory access, and its load result reads zero.
- R8: In every other packet shape, the uncancelled valid slots are accessed in slot order, slot 0 first, with no probe. Each slot reads or writes according to its store flag.
- R9: pkt_ready is high only while no packet is in progress. A memory request holds mem_kind, mem_addr and mem_be steady until mem_done. Each accepted packet yields exactly one done_o pulse, and pkt_ready is high again in the next cycle.
- R10: During reset, pkt_ready is 1 and mem_req and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Sequencer idle, packet taken when valid |
| s0_vld | input | 1 | Slot 0 holds a memory operation |
| s0_store | input | 1 | Slot 0 is a store (else load) |
| s0_pred | input | 1 | Slot 0 predicate, 0 cancels the slot |
| s0_sign | input | 1 | Slot 0 load is sign-extended |
| s0_size | input | 2 | Slot 0 size code |
| s0_addr | input | ADDR_W | Slot 0 byte address |
| s0_wdata | input | DATA_W | Slot 0 store data, right-aligned |
| s1_vld | input | 1 | Slot 1 holds a memory operation |
| s1_store | input | 1 | Slot 1 is a store (else load) |
| s1_pred | input | 1 | Slot 1 predicate |
| s1_sign | input | 1 | Slot 1 load is sign-extended |
| s1_size | input | 2 | Slot 1 size code |
| s1_addr | input | ADDR_W | Slot 1 byte address |
| s1_wdata | input | DATA_W | Slot 1 store data, right-aligned |
| mem_req | output | 1 | Memory request pending |
| mem_kind | output | 2 | 1 probe, 2 read, 3 write |
| mem_addr | output | ADDR_W | Word-aligned address |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_wdata | output | DATA_W | Lane-aligned write data |
| mem_done | input | 1 | Current request complete |
| mem_rdata | input | DATA_W | Read word, valid with mem_done |
| mem_fault | input | 1 | Probe fault, valid with mem_done |
| done_o | output | 1 | One-cycle packet completion pulse |
| err_o | output | 1 | Packet ended on a probe fault |
| cancel_o | output | 2 | Per-slot cancel mask |
| rd0_o | output | DATA_W | Slot 0 load result |
| rd1_o | output | DATA_W | Slot 1 load result |

## Verification
A corrupted step plan or slot index shows at the memory port on the next request. The order of request kinds changes, a probe appears or goes missing, or a write lands at the wrong address. The bench captures every request kind per packet and compares the trace as soon as done_o pulses. A wrong lane offset or extension corrupts the load result on that same done_o. A store committed after a faulting probe stays hidden until a later read of that address, so the bench reads back such addresses in the following packet. A stuck state machine leaves pkt_ready low, and the cycle after done_o checks for that.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PROBE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_st_e;

    typedef struct packed {
        acc_e kind;
        logic slot;
    } step_t;

    function automatic step_t mk_step(input logic en, input acc_e kind, input logic slot);
        step_t s;
        s.kind = en ? kind : ACC_NONE;
        s.slot = en ? slot : 1'b0;
        return s;
    endfunction

    function automatic acc_e op_of(input logic is_store);
        return is_store ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/sbl_lane_pack.sv
module sbl_lane_pack #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            size,
    input  logic [DATA_W-1:0]     wdata,
    output logic [ADDR_W-1:0]     word_addr,
    output logic [DATA_W/8-1:0]   be,
    output logic [DATA_W-1:0]     wdata_al
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   span;
    logic [OFF_W:0]   lo;
    logic [OFF_W:0]   hi;

    assign off  = addr[OFF_W-1:0];
    assign span = (OFF_W+1)'(1) << size;
    assign lo   = {1'b0, off};
    assign hi   = lo + span;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign be[b] = (lo <= (OFF_W+1)'(b)) && ((OFF_W+1)'(b) < hi);
    end

    assign wdata_al  = wdata << {off, 3'b000};
    assign word_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/sbl_load_ext.sv
module sbl_load_ext #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]             rdata,
    input  logic [$clog2(DATA_W/8)-1:0]   off,
    input  logic [1:0]                    size,
    input  logic                          sign,
    output logic [DATA_W-1:0]             value
);
    localparam int NB_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] sh;
    logic [NB_W-1:0]   nbits;
    logic              msb;

    assign sh    = rdata >> {off, 3'b000};
    assign nbits = NB_W'(8) << size;

    always_comb begin
        case (size)
            2'd0:    msb = sh[7];
            2'd1:    msb = sh[15];
            2'd2:    msb = sh[31];
            default: msb = sh[DATA_W-1];
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign value[i] = (NB_W'(i) < nbits) ? sh[i] : (sign & msb);
    end

endmodule

// File: rtl/pkt_sbl_seq.sv
module pkt_sbl_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_valid,
    output logic                  pkt_ready,
    input  logic                  s0_vld,
    input  logic                  s0_store,
    input  logic                  s0_pred,
    input  logic                  s0_sign,
    input  logic [1:0]            s0_size,
    input  logic [ADDR_W-1:0]     s0_addr,
    input  logic [DATA_W-1:0]     s0_wdata,
    input  logic                  s1_vld,
    input  logic                  s1_store,
    input  logic                  s1_pred,
    input  logic                  s1_sign,
    input  logic [1:0]            s1_size,
    input  logic [ADDR_W-1:0]     s1_addr,
    input  logic [DATA_W-1:0]     s1_wdata,
    output logic                  mem_req,
    output logic [1:0]            mem_kind,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_done,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_fault,
    output logic                  done_o,
    output logic                  err_o,
    output logic [1:0]            cancel_o,
    output logic [DATA_W-1:0]     rd0_o,
    output logic [DATA_W-1:0]     rd1_o
);
    import sbl_pkg::*;

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int STEPS = 3;

    typedef struct packed {
        logic              vld;
        logic              store;
        logic              pred;
        logic              sign;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } slot_t;

    typedef struct packed {
        seq_st_e                  st;
        logic [1:0]               idx;
        step_t [STEPS-1:0]        plan;
        slot_t [1:0]              slot;
        logic [1:0]               cancel;
        logic                     err;
        logic [1:0][DATA_W-1:0]   rd;
    } regs_t;

    regs_t q, d;

    slot_t [1:0]        in_slot;
    step_t              cur;
    slot_t              cur_slot;
    logic               ordered;
    logic               adv;
    logic [ADDR_W-1:0]  lane_addr;
    logic [LANES-1:0]   lane_be;
    logic [DATA_W-1:0]  lane_wdata;
    logic [DATA_W-1:0]  ld_val;

    assign in_slot[0] = '{vld: s0_vld, store: s0_store, pred: s0_pred, sign: s0_sign,
                          size: s0_size, addr: s0_addr, wdata: s0_wdata};
    assign in_slot[1] = '{vld: s1_vld, store: s1_store, pred: s1_pred, sign: s1_sign,
                          size: s1_size, addr: s1_addr, wdata: s1_wdata};

    assign cur      = q.plan[q.idx];
    assign cur_slot = q.slot[cur.slot];

    sbl_lane_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .addr      (cur_slot.addr),
        .size      (cur_slot.size),
        .wdata     (cur_slot.wdata),
        .word_addr (lane_addr),
        .be        (lane_be),
        .wdata_al  (lane_wdata)
    );

    sbl_load_ext #(.DATA_W(DATA_W)) u_ext (
        .rdata (mem_rdata),
        .off   (cur_slot.addr[OFF_W-1:0]),
        .size  (cur_slot.size),
        .sign  (cur_slot.sign),
        .value (ld_val)
    );

    // next-state logic
    always_comb begin
        d       = q;
        adv     = 1'b0;
        ordered = in_slot[1].vld & in_slot[1].store & in_slot[0].vld & ~in_slot[0].store;
        case (q.st)
            SQ_IDLE: begin
                if (pkt_valid) begin
                    d.st     = SQ_RUN;
                    d.idx    = 2'd0;
                    d.slot   = in_slot;
                    d.err    = 1'b0;
                    d.rd     = '0;
                    d.cancel = {in_slot[1].vld & ~in_slot[1].pred,
                                in_slot[0].vld & ~in_slot[0].pred};
                    if (ordered) begin
                        // probe the load, commit the store, then load
                        d.plan[0] = mk_step(in_slot[0].pred, ACC_PROBE, 1'b0);
                        d.plan[1] = mk_step(in_slot[1].pred, ACC_WRITE, 1'b1);
                        d.plan[2] = mk_step(in_slot[0].pred, ACC_READ,  1'b0);
                    end else begin
                        d.plan[0] = mk_step(in_slot[0].vld & in_slot[0].pred,
                                            op_of(in_slot[0].store), 1'b0);
                        d.plan[1] = mk_step(in_slot[1].vld & in_slot[1].pred,
                                            op_of(in_slot[1].store), 1'b1);
                        d.plan[2] = mk_step(1'b0, ACC_NONE, 1'b0);
                    end
                end
            end
            SQ_RUN: begin
                if (cur.kind == ACC_NONE) begin
                    adv = 1'b1;
                end else if (mem_done) begin
                    case (cur.kind)
                        ACC_PROBE: begin
                            if (mem_fault) begin
                                d.err    = 1'b1;
                                d.cancel = {q.slot[1].vld, q.slot[0].vld};
                                d.st     = SQ_DONE;
                            end else begin
                                adv = 1'b1;
                            end
                        end
                        ACC_READ: begin
                            d.rd[cur.slot] = ld_val;
                            adv = 1'b1;
                        end
                        default: adv = 1'b1;
                    endcase
                end
                if (adv) begin
                    if (q.idx == 2'(STEPS - 1)) d.st = SQ_DONE;
                    else                        d.idx = q.idx + 2'd1;
                end
            end
            SQ_DONE: d.st = SQ_IDLE;
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pkt_ready = (q.st == SQ_IDLE);
    assign done_o    = (q.st == SQ_DONE);
    assign mem_req   = (q.st == SQ_RUN) && (cur.kind != ACC_NONE);
    assign mem_kind  = cur.kind;
    assign mem_addr  = lane_addr;
    assign mem_be    = lane_be;
    assign mem_wdata = (cur.kind == ACC_WRITE) ? lane_wdata : '0;
    assign err_o     = q.err;
    assign cancel_o  = q.cancel;
    assign rd0_o     = q.rd[0];
    assign rd1_o     = q.rd[1];

    // request stays put until the memory completes it
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_kind) && $stable(mem_be)));

    // a faulting probe ends the packet with no further access
    assert_fault_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done && mem_kind == 2'd1 && mem_fault) |=> (done_o && err_o && !mem_req));

    // byte enables cover exactly one legal access size
    assert_be_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4 || $countones(mem_be) == 8));

    // completion returns to idle on the next cycle
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (pkt_ready && !done_o));

    // no memory traffic while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!mem_req && !done_o));

endmodule

// File: tb/tb_pkt_sbl_seq.sv
module tb_pkt_sbl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 1;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic        s0_vld = 0, s0_store = 0, s0_pred = 0, s0_sign = 0;
    logic [1:0]  s0_size = 0;
    logic [31:0] s0_addr = 0;
    logic [63:0] s0_wdata = 0;
    logic        s1_vld = 0, s1_store = 0, s1_pred = 0, s1_sign = 0;
    logic [1:0]  s1_size = 0;
    logic [31:0] s1_addr = 0;
    logic [63:0] s1_wdata = 0;
    logic        mem_req;
    logic [1:0]  mem_kind;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_done = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic        done_o, err_o;
    logic [1:0]  cancel_o;
    logic [63:0] rd0_o, rd1_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_sbl_seq dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .s0_vld(s0_vld), .s0_store(s0_store), .s0_pred(s0_pred), .s0_sign(s0_sign),
        .s0_size(s0_size), .s0_addr(s0_addr), .s0_wdata(s0_wdata),
        .s1_vld(s1_vld), .s1_store(s1_store), .s1_pred(s1_pred), .s1_sign(s1_sign),
        .s1_size(s1_size), .s1_addr(s1_addr), .s1_wdata(s1_wdata),
        .mem_req(mem_req), .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .done_o(done_o), .err_o(err_o), .cancel_o(cancel_o),
        .rd0_o(rd0_o), .rd1_o(rd1_o)
    );

    typedef struct {
        bit          vld, st, pred, sgn;
        bit [1:0]    size;
        logic [31:0] addr;
        logic [63:0] data;
    } bslot_t;

    typedef struct {
        logic [63:0] rd0, rd1;
        logic [1:0]  cancel;
        bit          err;
        logic [5:0]  trace;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    logic [7:0] sh [256];
    logic [5:0] trace;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // ---------------- memory model ----------------
    logic [63:0] mem [32];
    bit          busy = 0;
    int          wcnt = 0;
    logic [1:0]  l_kind;
    logic [31:0] l_addr;
    logic [7:0]  l_be;
    logic [63:0] l_wdata;

    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= '0;
            busy <= 0;
            trace <= '0;
        end else begin
            if (pkt_valid && pkt_ready) trace <= '0;
            if (mem_req && !mem_done && !busy) begin
                busy    <= 1;
                wcnt    <= MEM_LAT;
                l_kind  <= mem_kind;
                l_addr  <= mem_addr;
                l_be    <= mem_be;
                l_wdata <= mem_wdata;
                trace   <= {trace[3:0], mem_kind};
                chk(mem_addr[2:0] == 3'b000, "R5", "word-aligned mem_addr", 64'(mem_addr), 64'(mem_addr & ~32'h7));
            end else if (busy) begin
                if (wcnt == 0) begin
                    logic [63:0] w;
                    busy      <= 0;
                    mem_done  <= 1'b1;
                    mem_fault <= (l_kind == 2'd1) && l_addr[31];
                    mem_rdata <= mem[l_addr[7:3]];
                    if (l_kind == 2'd3) begin
                        w = mem[l_addr[7:3]];
                        for (int b = 0; b < 8; b++)
                            if (l_be[b]) w[8*b +: 8] = l_wdata[8*b +: 8];
                        mem[l_addr[7:3]] <= w;
                    end
                end else begin
                    wcnt <= wcnt - 1;
                end
            end
        end
    end

    // ---------------- scoreboard monitor ----------------
    bit ready_pend = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ready_pend) begin
                chk(pkt_ready == 1'b1, "R9", "ready after done", 64'(pkt_ready), 64'd1);
                ready_pend = 0;
            end
            if (done_o) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done pulse", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(rd0_o == e.rd0, "R2/R4", {e.tag, " rd0"}, rd0_o, e.rd0);
                    chk(rd1_o == e.rd1, "R2/R4", {e.tag, " rd1"}, rd1_o, e.rd1);
                    chk(cancel_o == e.cancel, "R7", {e.tag, " cancel"}, 64'(cancel_o), 64'(e.cancel));
                    chk(err_o == e.err, "R3", {e.tag, " err"}, 64'(err_o), 64'(e.err));
                    chk(trace == e.trace, "R1/R8", {e.tag, " access order"}, 64'(trace), 64'(e.trace));
                end
                ready_pend = 1;
            end
        end
    end

    // ---------------- reference and driver ----------------
    function automatic logic [63:0] ref_read(input logic [31:0] a, input bit [1:0] sz, input bit sg);
        logic [63:0] v = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) v[8*i +: 8] = sh[8'(a[7:0] + 8'(i))];
        if (sg && n < 8 && v[8*n-1]) v = v | ~((64'd1 << (8*n)) - 64'd1);
        return v;
    endfunction

    task automatic ref_write(input logic [31:0] a, input bit [1:0] sz, input logic [63:0] dt);
        int n = 1 << sz;
        for (int i = 0; i < n; i++) sh[8'(a[7:0] + 8'(i))] = dt[8*i +: 8];
    endtask

    function automatic bslot_t mk(input bit vld, input bit st, input bit pred, input bit sgn,
                                  input bit [1:0] size, input logic [31:0] addr, input logic [63:0] data);
        bslot_t s;
        s.vld = vld; s.st = st; s.pred = pred; s.sgn = sgn;
        s.size = size; s.addr = addr; s.data = data;
        return s;
    endfunction

    task automatic send(input string tag, input bslot_t a, input bslot_t b);
        exp_t e;
        bit ordered;
        e.rd0 = '0; e.rd1 = '0; e.err = 0; e.trace = '0; e.tag = tag;
        e.cancel = {b.vld & ~b.pred, a.vld & ~a.pred};
        ordered = b.vld && b.st && a.vld && !a.st;
        if (ordered) begin
            if (a.pred) e.trace = {e.trace[3:0], 2'd1};
            if (a.pred && a.addr[31]) begin
                e.err = 1; e.cancel = 2'b11;
            end else begin
                if (b.pred) begin ref_write(b.addr, b.size, b.data); e.trace = {e.trace[3:0], 2'd3}; end
                if (a.pred) begin e.rd0 = ref_read(a.addr, a.size, a.sgn); e.trace = {e.trace[3:0], 2'd2}; end
            end
        end else begin
            if (a.vld && a.pred) begin
                if (a.st) begin ref_write(a.addr, a.size, a.data); e.trace = {e.trace[3:0], 2'd3}; end
                else begin e.rd0 = ref_read(a.addr, a.size, a.sgn); e.trace = {e.trace[3:0], 2'd2}; end
            end
            if (b.vld && b.pred) begin
                if (b.st) begin ref_write(b.addr, b.size, b.data); e.trace = {e.trace[3:0], 2'd3}; end
                else begin e.rd1 = ref_read(b.addr, b.size, b.sgn); e.trace = {e.trace[3:0], 2'd2}; end
            end
        end
        expq.push_back(e);
        @(negedge clk);
        s0_vld = a.vld; s0_store = a.st; s0_pred = a.pred; s0_sign = a.sgn;
        s0_size = a.size; s0_addr = a.addr; s0_wdata = a.data;
        s1_vld = b.vld; s1_store = b.st; s1_pred = b.pred; s1_sign = b.sgn;
        s1_size = b.size; s1_addr = b.addr; s1_wdata = b.data;
        pkt_valid = 1'b1;
        @(posedge clk);
        while (!pkt_ready) @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        wait (expq.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    bslot_t none;

    initial begin
        for (int i = 0; i < 256; i++) sh[i] = 8'h00;
        none = mk(0, 0, 0, 0, 2'd0, 32'h0, 64'h0);
        repeat (3) @(negedge clk);
        chk(pkt_ready == 1'b1, "R10", "ready in reset", 64'(pkt_ready), 64'd1);
        chk(mem_req == 1'b0, "R10", "no request in reset", 64'(mem_req), 64'd0);
        chk(done_o == 1'b0, "R10", "no done in reset", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: single slot-0 store, plain order
        send("R8 preload", mk(1, 1, 1, 0, 2'd3, 32'h00, 64'h1122334455667788), none);
        // R1 R2 R4 R5: halfword store into the word the load reads
        send("R1 overlap", mk(1, 0, 1, 0, 2'd2, 32'h00, 64'h0),
                           mk(1, 1, 1, 0, 2'd1, 32'h02, 64'h0000_0000_0000_BEEF));
        // R2 R4: signed byte load of freshly stored byte
        send("R2 sbyte", mk(1, 0, 1, 1, 2'd0, 32'h03, 64'h0),
                         mk(1, 1, 1, 0, 2'd0, 32'h03, 64'hFFFF_FFFF_FFFF_FF9A));
        // R3: probe fault suppresses the store
        send("R3 fault", mk(1, 0, 1, 0, 2'd2, 32'h8000_0000, 64'h0),
                         mk(1, 1, 1, 0, 2'd3, 32'h10, 64'h0000_DEAD_0000_DEAD));
        send("R3 readback", mk(1, 0, 1, 0, 2'd3, 32'h10, 64'h0), none);
        // R6 R7: false-predicate load, store still lands
        send("R6 predload", mk(1, 0, 0, 0, 2'd2, 32'h14, 64'h0),
                            mk(1, 1, 1, 0, 2'd2, 32'h14, 64'h0000_0000_CAFE_F00D));
        send("R6 readback", mk(1, 0, 1, 0, 2'd2, 32'h14, 64'h0), none);
        // R4: signed word load
        send("R4 sword", mk(1, 0, 1, 1, 2'd2, 32'h14, 64'h0), none);
        // R8 R2: slot-0 store then slot-1 signed halfword load
        send("R8 s0store", mk(1, 1, 1, 0, 2'd1, 32'h20, 64'h0000_0000_0000_8001),
                           mk(1, 0, 1, 1, 2'd1, 32'h20, 64'h0));
        // R8 R4: two loads
        send("R8 twoload", mk(1, 0, 1, 0, 2'd3, 32'h00, 64'h0),
                           mk(1, 0, 1, 0, 2'd1, 32'h16, 64'h0));
        // R7: cancelled slot-1 store, memory untouched
        send("R7 cancelst", mk(1, 0, 1, 0, 2'd3, 32'h00, 64'h0),
                            mk(1, 1, 0, 0, 2'd3, 32'h00, 64'hFFFF_FFFF_FFFF_FFFF));
        // R5: unsigned byte at upper lane
        send("R5 hilane", mk(1, 1, 1, 0, 2'd0, 32'h2F, 64'h0000_0000_0000_00C3),
                          mk(1, 0, 1, 0, 2'd0, 32'h2F, 64'h0));
        repeat (4) @(negedge clk);
        report();
    end

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd >= WDOG_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=%0d expected=<%0d", wd, WDOG_LIMIT);
            report();
        end
    end

endmodule